// File: doc/BRIEF.md
# Phase-Selected Byte-Interleaved Serializer

This block turns 128-bit frames into a single serial bit stream, one bit per enabled cycle of its clock. A frame is an 8-bit fixed header followed by 120 payload bits. The frame is broken into eight 16-bit words, and each word is split into two bytes. The upper byte is captured on the rising clock edge and the lower byte on the following falling edge. A 16-position one-hot phase ring then walks a 16-input multiplexer across the two bytes. No bit-rate shift register is involved. In this cycle-accurate model, a phase ring stepping on a bit-rate enable stands in for the analog multi-phase delay line.

The ring is held at phase 0 and the line stays at 0 until a frame is offered. The first enabled cycle that sees a valid frame becomes the first frame boundary. From then on, a boundary falls after every 128 enabled cycles. If no valid frame is present at a boundary, the block sends an idle frame: the header followed by zeros. Several instances can be placed side by side to widen the aggregate link.

Top module: `phase_serializer`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `ser_out` is 0 and `phase_sel` is 16'h0001.
- R2: Before the first frame is accepted, `ser_out` stays 0 and `phase_sel` stays 16'h0001. A frame is accepted only in a cycle with `bit_en` and `frame_valid` both high.
- R3: An accepted frame is the 128-bit value {8'hA5, payload[119:0]}. It is sent most significant bit first, so frame bit 127 appears in the cycle after the accepting edge and bit 0 appears last.
- R4: `phase_sel` always has exactly one bit set. Once running, each enabled cycle moves that bit one position up, and position 15 wraps to position 0.
- R5: In a cycle with `bit_en` low, neither `phase_sel` nor `ser_out` changes at the next edge.
- R6: `frame_valid` and `frame_payload` are ignored except at a frame boundary. A boundary is the enabled cycle in which the 128th bit of the current frame is on the line.
- R7: At a boundary with `frame_valid` low, the next frame sent is {8'hA5, 120'b0}.
- R8: Within each 16-bit word, phases 0 to 7 carry the upper byte MSB first, and phases 8 to 15 carry the lower byte MSB first. Words leave most significant first.
- R9: Frames follow each other without a gap. The first bit of the next frame appears in the enabled cycle right after the last bit of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bytes are captured on both edges |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate enable; one serial bit per enabled cycle |
| frame_valid | input | 1 | A new payload is offered |
| frame_payload | input | 120 | Payload bits of the offered frame |
| ser_out | output | 1 | Serial data output |
| phase_sel | output | 16 | One-hot multiplexer select (current phase) |

## Verification
Three events can land on the same edge: the phase-15 wrap of the last word, the capture of the next frame, and the load of its first word. The bench provokes this by running long stretches of back-to-back frames under a random enable. The enable sometimes drops exactly on the final phase. At random boundaries `frame_valid` is high or low, so a real frame and an idle frame alternate with no gap between them. Each output cycle is judged against a bench model that tracks a bit counter and the accepted frame. Stalled cycles are checked to hold both outputs.

// File: rtl/phase_serializer.sv
module phase_serializer #(
  parameter logic [7:0] HEADER = 8'hA5,
  parameter int BYTE_W = 8,
  parameter int NWORD  = 8,
  localparam int WORD_W  = 2 * BYTE_W,
  localparam int NPH     = WORD_W,
  localparam int FRAME_W = WORD_W * NWORD,
  localparam int PAY_W   = FRAME_W - BYTE_W,
  localparam int IDX_W   = $clog2(NWORD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             frame_valid,
  input  logic [PAY_W-1:0] frame_payload,
  output logic             ser_out,
  output logic [NPH-1:0]   phase_sel
);

  logic               running;
  logic [IDX_W-1:0]   word_idx;
  logic [FRAME_W-1:0] frame_q;
  logic [BYTE_W-1:0]  rise_q;
  logic [BYTE_W-1:0]  fall_stage;
  logic [BYTE_W-1:0]  fall_q;
  logic [NPH-1:0]     tap;

  wire last_phase = phase_sel[NPH-1];
  wire frame_end  = running & last_phase & (word_idx == IDX_W'(NWORD - 1));
  wire boundary   = bit_en & (~running | frame_end);
  wire take       = boundary & (running | frame_valid);
  wire word_step  = bit_en & running & last_phase & ~frame_end;

  wire [FRAME_W-1:0] next_frame = {HEADER, frame_valid ? frame_payload : PAY_W'(0)};
  wire [IDX_W-1:0]   nxt_idx    = word_idx + IDX_W'(1);
  wire [FRAME_W-1:0] shifted    = frame_q << (nxt_idx * WORD_W);
  wire [WORD_W-1:0]  nxt_word   = shifted[FRAME_W-1 -: WORD_W];
  wire [NPH-1:0]     ring_next  = {phase_sel[NPH-2:0], phase_sel[NPH-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      word_idx   <= '0;
      frame_q    <= '0;
      rise_q     <= '0;
      fall_stage <= '0;
      phase_sel  <= NPH'(1);
    end else if (take) begin
      running    <= 1'b1;
      word_idx   <= '0;
      frame_q    <= next_frame;
      rise_q     <= next_frame[FRAME_W-1 -: BYTE_W];
      fall_stage <= next_frame[FRAME_W-BYTE_W-1 -: BYTE_W];
      phase_sel  <= NPH'(1);
    end else if (word_step) begin
      word_idx   <= nxt_idx;
      rise_q     <= nxt_word[WORD_W-1 -: BYTE_W];
      fall_stage <= nxt_word[BYTE_W-1:0];
      phase_sel  <= ring_next;
    end else if (bit_en & running) begin
      phase_sel  <= ring_next;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= fall_stage;
  end

  for (genvar k = 0; k < NPH; k++) begin : g_tap
    if (k < BYTE_W) begin : g_rise
      assign tap[k] = rise_q[BYTE_W-1-k];
    end else begin : g_fall
      assign tap[k] = fall_q[WORD_W-1-k];
    end
  end

  assign ser_out = running & |(phase_sel & tap);

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_sel) == 1); // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    running && bit_en |=> phase_sel == {$past(phase_sel[NPH-2:0]), $past(phase_sel[NPH-1])}); // R4
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(phase_sel) && $stable(ser_out)); // R5
  AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !running |-> !ser_out && phase_sel[0]); // R2
  AST_HEADER_FIRST: assert property (@(posedge clk) disable iff (rst)
    running && word_idx == '0 && phase_sel[0] |-> rise_q == HEADER); // R3
  AST_IDLE_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    take && !frame_valid |=> frame_q[PAY_W-1:0] == '0); // R7

endmodule

// File: tb/test_phase_serializer.sv
module test_phase_serializer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bit_en = 1'b0;
  logic         frame_valid = 1'b0;
  logic [119:0] frame_payload = '0;
  logic         ser_out;
  logic [15:0]  phase_sel;

  int checks = 0;
  int fails  = 0;

  bit           m_st = 1'b0;
  int           m_cnt = 0;
  logic [127:0] m_cur = '0;
  bit           m_new = 1'b0;
  bit           m_idle = 1'b0;
  logic         prev_out = 1'b0;
  logic [15:0]  prev_sel = 16'h0001;

  phase_serializer i_phase_serializer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_valid(frame_valid),
    .frame_payload(frame_payload), .ser_out(ser_out), .phase_sel(phase_sel)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [119:0] rnd_payload();
    logic [127:0] r;
    r = {$urandom, $urandom, $urandom, $urandom};
    return r[119:0];
  endfunction

  task automatic cyc(input logic en, input logic v, input logic [119:0] pl, input logic r);
    string tag;
    bit mid_valid;
    bit_en = en; frame_valid = v; frame_payload = pl; rst = r;
    @(posedge clk);
    m_new = 1'b0;
    mid_valid = 1'b0;
    if (r) begin
      m_st = 1'b0; m_cnt = 0;
    end else if (en && (!m_st || m_cnt == 127)) begin
      if (v || m_st) begin
        m_cur = {8'hA5, v ? pl : 120'b0};
        m_idle = !v; m_cnt = 0; m_st = 1'b1; m_new = 1'b1;
      end
    end else if (en && m_st) begin
      m_cnt++;
      mid_valid = v;
    end
    @(negedge clk); #1;
    if (r) tag = "R1";
    else if (!m_st) tag = "R2";
    else if (!en) tag = "R5";
    else if (mid_valid) tag = "R6";
    else if (m_new) tag = m_idle ? "R7" : "R9";
    else if (m_cnt % 16 >= 8) tag = "R8";
    else tag = "R3";
    if (!en && !r) begin
      chk({15'b0, ser_out}, {15'b0, prev_out}, "R5 hold out");
      chk(phase_sel, prev_sel, "R5 hold phase");
    end
    chk({15'b0, ser_out}, {15'b0, m_st ? m_cur[127 - m_cnt] : 1'b0}, tag);
    chk(phase_sel, 16'h0001 << (m_cnt % 16), r ? "R1 phase" : "R4 phase");
    prev_out = ser_out;
    prev_sel = phase_sel;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    @(negedge clk); #1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, rnd_payload(), 1'b1);
    cyc(1'b0, 1'b0, '0, 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, rnd_payload(), 1'b0);
    cyc(1'b0, 1'b1, rnd_payload(), 1'b0);
    cyc(1'b1, 1'b1, {120{1'b1}}, 1'b0);
    for (int i = 0; i < 127; i++) cyc(1'b1, i[0], rnd_payload(), 1'b0);
    for (int i = 0; i < 130; i++) cyc(1'b1, 1'b0, rnd_payload(), 1'b0);
    for (int i = 0; i < 126; i++) cyc(1'b1, 1'b1, 120'h0, 1'b0);
    cyc(1'b0, 1'b1, rnd_payload(), 1'b0);
    cyc(1'b1, 1'b1, 120'h0, 1'b0);
    cyc(1'b0, 1'b1, rnd_payload(), 1'b0);
    cyc(1'b1, 1'b1, {8'h5A, 112'h0123456789abcdef0123456789ab}, 1'b0);
    for (int i = 0; i < 40 * 128; i++)
      cyc(($urandom % 4) != 0, ($urandom % 10) < 7, rnd_payload(), 1'b0);
    cyc(1'b1, 1'b1, rnd_payload(), 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, rnd_payload(), 1'b0);
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b1, rnd_payload(), 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule